// File: doc/BRIEF.md
# Rank Power-Down Manager

This block decides, for one rank of a DRAM memory controller, when the rank may sleep and when it must wake. It keeps three counts: reads queued for the rank, writes queued for the rank, and scheduled activity that has not finished yet. Scheduled activity covers pending precharges, read responses in flight and write-done markers. A rank can fall asleep only at a moment when both the queue for the coming bus direction and the activity count are empty. The kind of sleep depends on the bank state. With banks still open the rank takes the open-bank nap. With every bank closed it takes the closed-bank nap. From the closed-bank nap the rank can drop into self-refresh.

The command scheduler drives enqueue, issue and completion pulses, the count of open banks, the direction of the next bus phase, a wake request and a self-refresh request. The block returns the power state, one-cycle entry and exit strobes, and a command-block flag. The command-block flag holds off column, precharge and activate commands while the rank sleeps and for the exit latency after it wakes. A saturating counter totals the cycles spent asleep.

Top module: `rankSleepCtrl`

## Requirements
- R1: After reset the state is idle (code 0), the command-block flag, both strobes and the sleep-cycle counter are 0, and all internal counts are empty.
- R2: The state codes are idle 0, banks-open 1, open nap 2, closed nap 3, self-refresh 4 and refreshing 5. In idle, `refActive` high moves to refreshing (priority over everything else), otherwise a non-zero `banksOpen` moves to banks-open; refreshing returns to idle once `refActive` is low.
- R3: The rank is ready when, after this cycle's pulses are counted (reads: +`rdEnq` −`rdDone`; writes: +`wrEnq` −`wrIssue`; activity: +`preSched` +`rdRespSched` +`wrIssue` −`preDone` −`rdDone` −`wrDone`), the queue chosen by `nextDirWrite` (1 = writes, 0 = reads) is empty and the activity count is zero. No transition to sleep happens without a triggering completion.
- R4: A `rdDone` pulse that leaves the rank ready moves banks-open to the open nap and idle to the closed nap; if the rank is not ready the state is unchanged.
- R5: In banks-open, a `preDone` pulse while `banksOpen` equals 1 moves to the closed nap if the rank is ready and to idle otherwise; this takes priority over R4.
- R6: Once a nap or self-refresh has been entered, the rank stays asleep for at least `MIN_SLEEP` cycles. A wake request that arrives during that hold, or in the entry cycle, is remembered and served as soon as the hold ends.
- R7: A wake request (`wakeReq` or a remembered one) returns the open nap to banks-open and the closed nap to idle.
- R8: In the closed nap, with the hold over, no wake pending and the rank ready, `srefReq` enters self-refresh. `srefReq` in any other state is ignored. In self-refresh `wakeReq` is ignored, and the rank leaves for idle once the hold is over and either queue count is non-zero.
- R9: `cmdBlock` is high in every sleep state and for exactly `TXP_CYC` cycles after leaving a nap, or `TXS_CYC` cycles after leaving self-refresh, counted from the first cycle in the new state.
- R10: `enterStb` is high for exactly the first cycle in a sleep state entered from outside sleep or in self-refresh entered from the closed nap. `exitStb` is high for exactly the first cycle after leaving sleep. The two are never high together.
- R11: `idleCycles` increases by one for every cycle spent in the open nap, the closed nap or self-refresh, and saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEnq | input | 1 | A read for this rank entered the queue |
| wrEnq | input | 1 | A write for this rank entered the queue |
| rdRespSched | input | 1 | A read response was scheduled (activity +1) |
| rdDone | input | 1 | A read completed (read queue −1, activity −1) |
| wrIssue | input | 1 | A write left the queue for the bus (write queue −1, activity +1) |
| wrDone | input | 1 | A write transfer finished (activity −1) |
| preSched | input | 1 | A new precharge was scheduled (activity +1) |
| preDone | input | 1 | A precharge finished (activity −1) |
| banksOpen | input | $clog2(BANKS+1) | Open banks before this cycle's precharge completes |
| nextDirWrite | input | 1 | Direction of the coming bus phase, 1 = writes |
| refActive | input | 1 | The refresh sequencer owns the rank |
| wakeReq | input | 1 | A read or write targets this rank |
| srefReq | input | 1 | Request to move from the closed nap into self-refresh |
| pwrState | output | 3 | Current power state code |
| enterStb | output | 1 | First cycle of a sleep entry |
| exitStb | output | 1 | First cycle after a wake-up |
| cmdBlock | output | 1 | Column, precharge and activate commands must wait |
| idleCycles | output | IDLE_W | Saturating count of cycles asleep |

## Verification
The case that needs care is a wake request that lands in the same cycle as a sleep entry, or inside the minimum-sleep hold that follows it. The directed part raises `wakeReq` in the first sleep cycle. The random part fires wake, self-refresh and completion pulses together, so entry, hold and wake overlap many times. Each result is judged against a cycle-level reference model in the bench. The model must show the entry first and then the deferred exit at the exact cycle the hold ends, with `cmdBlock` released exactly one exit latency later. A self-refresh request that coincides with a wake request in the closed nap must yield the wake.

// File: rtl/rankPwrPkg.sv
`timescale 1ns/1ps
package rankPwrPkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_BANKS_OPEN = 3'd1,
    ST_NAP_OPEN   = 3'd2,
    ST_NAP_CLOSED = 3'd3,
    ST_SELF_REF   = 3'd4,
    ST_REFRESH    = 3'd5
  } pwrState_e;

  // strobes passed from the control FSM to the datapath
  typedef struct packed {
    logic enterNow;
    logic exitNow;
    logic fromSelfRef;
  } pwrStrobe_t;

  function automatic logic isSleep(input pwrState_e s);
    return (s == ST_NAP_OPEN) || (s == ST_NAP_CLOSED) || (s == ST_SELF_REF);
  endfunction

endpackage

// File: rtl/rankPwrDatapath.sv
`timescale 1ns/1ps
module rankPwrDatapath
  import rankPwrPkg::*;
#(
  parameter int QCNT_W    = 6,
  parameter int EV_W      = 6,
  parameter int IDLE_W    = 16,
  parameter int TXP_CYC   = 4,
  parameter int TXS_CYC   = 10,
  parameter int MIN_SLEEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEnq,
  input  logic              wrEnq,
  input  logic              rdRespSched,
  input  logic              rdDone,
  input  logic              wrIssue,
  input  logic              wrDone,
  input  logic              preSched,
  input  logic              preDone,
  input  logic              nextDirWrite,
  input  logic              sleeping,
  input  pwrStrobe_t        strobe,
  output logic              readyNext,
  output logic              holdOk,
  output logic              queuesBusy,
  output logic              windowBusy,
  output logic [IDLE_W-1:0] idleCycles
);

  localparam int WIN_MAX   = (TXP_CYC > TXS_CYC) ? TXP_CYC : TXS_CYC;
  localparam int WIN_W     = $clog2(WIN_MAX + 1);
  localparam int HOLD_W    = $clog2(MIN_SLEEP + 1);
  localparam int HOLD_LOAD = MIN_SLEEP - 1;
  localparam int NUM_Q     = 2;   // index 0: reads, 1: writes

  // queued read / write counters
  logic [NUM_Q-1:0]  qInc, qDec;
  logic [QCNT_W-1:0] qCnt  [NUM_Q];
  logic [QCNT_W-1:0] qNext [NUM_Q];

  assign qInc = {wrEnq, rdEnq};
  assign qDec = {wrIssue, rdDone};

  for (genvar g = 0; g < NUM_Q; g++) begin : gQueue
    assign qNext[g] = qCnt[g] + QCNT_W'(qInc[g]) - QCNT_W'(qDec[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) qCnt[g] <= '0;
      else       qCnt[g] <= qNext[g];
    end

    assert_no_queue_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
      qDec[g] |-> (qCnt[g] != '0) || qInc[g]);
  end

  // outstanding activity counter
  logic [1:0]      evInc, evDec;
  logic [EV_W-1:0] evCnt, evNext;

  assign evInc  = 2'(preSched) + 2'(rdRespSched) + 2'(wrIssue);
  assign evDec  = 2'(preDone) + 2'(rdDone) + 2'(wrDone);
  assign evNext = evCnt + EV_W'(evInc) - EV_W'(evDec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evCnt <= '0;
    else       evCnt <= evNext;
  end

  assert_no_event_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((EV_W+1)'(evCnt) + (EV_W+1)'(evInc)) >= (EV_W+1)'(evDec));

  // readiness looks at the counts after this cycle's pulses
  assign readyNext  = (nextDirWrite ? (qNext[1] == '0) : (qNext[0] == '0)) &&
                      (evNext == '0);
  assign queuesBusy = (qCnt[0] != '0) || (qCnt[1] != '0);

  // minimum residency after entry
  logic [HOLD_W-1:0] holdCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 holdCnt <= '0;
    else if (strobe.enterNow)  holdCnt <= HOLD_W'(HOLD_LOAD);
    else if (holdCnt != '0)    holdCnt <= holdCnt - 1'b1;
  end
  assign holdOk = (holdCnt == '0);

  // exit latency window
  logic [WIN_W-1:0] winCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      winCnt <= '0;
    else if (strobe.exitNow)
      winCnt <= strobe.fromSelfRef ? WIN_W'(TXS_CYC) : WIN_W'(TXP_CYC);
    else if (winCnt != '0)
      winCnt <= winCnt - 1'b1;
  end
  assign windowBusy = (winCnt != '0);

  assert_window_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.exitNow |=> windowBusy);

  // saturating sleep-cycle total
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      idleCycles <= '0;
    else if (sleeping && (idleCycles != '1))
      idleCycles <= idleCycles + 1'b1;
  end

  assert_idle_advance_R11: assert property (@(posedge clk) disable iff (!rstN)
    (sleeping && (idleCycles != '1)) |=> idleCycles == $past(idleCycles) + IDLE_W'(1));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !sleeping |=> $stable(idleCycles));

endmodule

// File: rtl/rankPwrCtrl.sv
`timescale 1ns/1ps
module rankPwrCtrl
  import rankPwrPkg::*;
#(
  parameter int BANK_CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BANK_CNT_W-1:0] banksOpen,
  input  logic                  refActive,
  input  logic                  wakeReq,
  input  logic                  srefReq,
  input  logic                  rdDone,
  input  logic                  preDone,
  input  logic                  readyNext,
  input  logic                  holdOk,
  input  logic                  queuesBusy,
  output pwrState_e             state,
  output logic                  sleepNow,
  output pwrStrobe_t            strobe,
  output logic                  enterStb,
  output logic                  exitStb
);

  pwrState_e nextState;
  logic      wakePend, wakeAny, sleepNext, lastBankClosing;

  assign wakeAny         = wakeReq || wakePend;
  assign lastBankClosing = preDone && (banksOpen == BANK_CNT_W'(1));

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (refActive)                nextState = ST_REFRESH;
        else if (banksOpen != '0)     nextState = ST_BANKS_OPEN;
        else if (rdDone && readyNext) nextState = ST_NAP_CLOSED;
      end
      ST_BANKS_OPEN: begin
        if (lastBankClosing)          nextState = readyNext ? ST_NAP_CLOSED : ST_IDLE;
        else if (rdDone && readyNext) nextState = ST_NAP_OPEN;
      end
      ST_NAP_OPEN: begin
        if (holdOk && wakeAny)        nextState = ST_BANKS_OPEN;
      end
      ST_NAP_CLOSED: begin
        if (holdOk && wakeAny)                     nextState = ST_IDLE;
        else if (holdOk && srefReq && readyNext)   nextState = ST_SELF_REF;
      end
      ST_SELF_REF: begin
        if (holdOk && queuesBusy)     nextState = ST_IDLE;
      end
      ST_REFRESH: begin
        if (!refActive)               nextState = ST_IDLE;
      end
      default:                        nextState = ST_IDLE;
    endcase
  end

  assign sleepNow  = isSleep(state);
  assign sleepNext = isSleep(nextState);

  always_comb begin
    strobe.enterNow    = (!sleepNow && sleepNext) ||
                         ((state == ST_NAP_CLOSED) && (nextState == ST_SELF_REF));
    strobe.exitNow     = sleepNow && !sleepNext;
    strobe.fromSelfRef = (state == ST_SELF_REF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wakePend <= 1'b0;
      enterStb <= 1'b0;
      exitStb  <= 1'b0;
    end else begin
      state    <= nextState;
      enterStb <= strobe.enterNow;
      exitStb  <= strobe.exitNow;
      if (strobe.exitNow)
        wakePend <= 1'b0;
      else if ((sleepNow || strobe.enterNow) && wakeReq)
        wakePend <= 1'b1;
    end
  end

  assert_min_sleep_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sleepNow && !holdOk) |=> sleepNow);

  assert_wake_to_open_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NAP_OPEN && !sleepNext) |=> state == ST_BANKS_OPEN);

  assert_selfref_stay_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SELF_REF && !queuesBusy) |=> state == ST_SELF_REF);

  assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(enterStb && exitStb));

  assert_exit_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    exitStb |-> !sleepNow);

endmodule

// File: rtl/rankSleepCtrl.sv
`timescale 1ns/1ps
module rankSleepCtrl
  import rankPwrPkg::*;
#(
  parameter int BANKS      = 8,
  parameter int QCNT_W     = 6,
  parameter int EV_W       = 6,
  parameter int IDLE_W     = 16,
  parameter int TXP_CYC    = 4,
  parameter int TXS_CYC    = 10,
  parameter int MIN_SLEEP  = 2,
  localparam int BANK_CNT_W = $clog2(BANKS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rdEnq,
  input  logic                  wrEnq,
  input  logic                  rdRespSched,
  input  logic                  rdDone,
  input  logic                  wrIssue,
  input  logic                  wrDone,
  input  logic                  preSched,
  input  logic                  preDone,
  input  logic [BANK_CNT_W-1:0] banksOpen,
  input  logic                  nextDirWrite,
  input  logic                  refActive,
  input  logic                  wakeReq,
  input  logic                  srefReq,
  output logic [2:0]            pwrState,
  output logic                  enterStb,
  output logic                  exitStb,
  output logic                  cmdBlock,
  output logic [IDLE_W-1:0]     idleCycles
);

  pwrState_e  state;
  pwrStrobe_t strobe;
  logic       sleepNow, readyNext, holdOk, queuesBusy, windowBusy;

  rankPwrCtrl #(.BANK_CNT_W(BANK_CNT_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .banksOpen  (banksOpen),
    .refActive  (refActive),
    .wakeReq    (wakeReq),
    .srefReq    (srefReq),
    .rdDone     (rdDone),
    .preDone    (preDone),
    .readyNext  (readyNext),
    .holdOk     (holdOk),
    .queuesBusy (queuesBusy),
    .state      (state),
    .sleepNow   (sleepNow),
    .strobe     (strobe),
    .enterStb   (enterStb),
    .exitStb    (exitStb)
  );

  rankPwrDatapath #(
    .QCNT_W    (QCNT_W),
    .EV_W      (EV_W),
    .IDLE_W    (IDLE_W),
    .TXP_CYC   (TXP_CYC),
    .TXS_CYC   (TXS_CYC),
    .MIN_SLEEP (MIN_SLEEP)
  ) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .rdEnq        (rdEnq),
    .wrEnq        (wrEnq),
    .rdRespSched  (rdRespSched),
    .rdDone       (rdDone),
    .wrIssue      (wrIssue),
    .wrDone       (wrDone),
    .preSched     (preSched),
    .preDone      (preDone),
    .nextDirWrite (nextDirWrite),
    .sleeping     (sleepNow),
    .strobe       (strobe),
    .readyNext    (readyNext),
    .holdOk       (holdOk),
    .queuesBusy   (queuesBusy),
    .windowBusy   (windowBusy),
    .idleCycles   (idleCycles)
  );

  assign pwrState = state;
  assign cmdBlock = sleepNow || windowBusy;

  assert_block_after_wake_R9: assert property (@(posedge clk) disable iff (!rstN)
    exitStb |-> cmdBlock);

endmodule

// File: tb/rankSleepCtrl_test.sv
`timescale 1ns/1ps
module rankSleepCtrl_test;

  localparam int TXP = 4;
  localparam int TXS = 10;
  localparam int MINS = 2;
  localparam int IDLE_BITS = 6;
  localparam int IDLE_MAX = (1 << IDLE_BITS) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdEnq = 0, wrEnq = 0, rdRespSched = 0, rdDone = 0, wrIssue = 0, wrDone = 0;
  logic preSched = 0, preDone = 0, nextDirWrite = 0, refActive = 0, wakeReq = 0, srefReq = 0;
  logic [3:0] banksOpen = '0;
  logic [2:0] pwrState;
  logic enterStb, exitStb, cmdBlock;
  logic [IDLE_BITS-1:0] idleCycles;

  always #10 clk = ~clk;

  rankSleepCtrl #(.IDLE_W(IDLE_BITS), .TXP_CYC(TXP), .TXS_CYC(TXS), .MIN_SLEEP(MINS)) uut (
    .clk(clk), .rstN(rstN), .rdEnq(rdEnq), .wrEnq(wrEnq), .rdRespSched(rdRespSched),
    .rdDone(rdDone), .wrIssue(wrIssue), .wrDone(wrDone), .preSched(preSched),
    .preDone(preDone), .banksOpen(banksOpen), .nextDirWrite(nextDirWrite),
    .refActive(refActive), .wakeReq(wakeReq), .srefReq(srefReq), .pwrState(pwrState),
    .enterStb(enterStb), .exitStb(exitStb), .cmdBlock(cmdBlock), .idleCycles(idleCycles)
  );

  int nChecks = 0;
  int nFail = 0;

  // reference model state
  int mRd = 0, mWr = 0, mEv = 0, mState = 0, mHold = 0, mExit = 0, mIdle = 0;
  bit mPend = 0, mEnter = 0, mLeave = 0;

  function automatic bit slp(input int s);
    return (s == 2) || (s == 3) || (s == 4);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    int rdN, wrN, evN, nxt;
    bit ready, holdOk, sl, wakeAny, enterNow, exitNow;
    rdN = mRd + rdEnq - rdDone;
    wrN = mWr + wrEnq - wrIssue;
    evN = mEv + preSched + rdRespSched + wrIssue - preDone - rdDone - wrDone;
    ready = (nextDirWrite ? (wrN == 0) : (rdN == 0)) && (evN == 0);
    holdOk = (mHold == 0);
    sl = slp(mState);
    wakeAny = wakeReq || mPend;
    nxt = mState;
    case (mState)
      0: if (refActive) nxt = 5; else if (banksOpen != 0) nxt = 1; else if (rdDone && ready) nxt = 3;
      1: if (preDone && banksOpen == 1) nxt = ready ? 3 : 0; else if (rdDone && ready) nxt = 2;
      2: if (holdOk && wakeAny) nxt = 1;
      3: if (holdOk && wakeAny) nxt = 0; else if (holdOk && srefReq && ready) nxt = 4;
      4: if (holdOk && (mRd != 0 || mWr != 0)) nxt = 0;
      5: if (!refActive) nxt = 0;
      default: nxt = 0;
    endcase
    enterNow = (!sl && slp(nxt)) || (mState == 3 && nxt == 4);
    exitNow = sl && !slp(nxt);
    if (sl && mIdle < IDLE_MAX) mIdle++;
    if (enterNow) mHold = MINS - 1; else if (mHold != 0) mHold--;
    if (exitNow) mExit = (mState == 4) ? TXS : TXP; else if (mExit != 0) mExit--;
    if (exitNow) mPend = 0; else if ((sl || enterNow) && wakeReq) mPend = 1;
    mEnter = enterNow;
    mLeave = exitNow;
    mState = nxt; mRd = rdN; mWr = wrN; mEv = evN;
  endtask

  task automatic clearPulses();
    rdEnq = 0; wrEnq = 0; rdRespSched = 0; rdDone = 0; wrIssue = 0; wrDone = 0;
    preSched = 0; preDone = 0; wakeReq = 0; srefReq = 0;
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    chk("R7 state", int'(pwrState), mState);
    chk("R9 cmdBlock", int'(cmdBlock), int'(slp(mState) || mExit != 0));
    chk("R10 enterStb", int'(enterStb), int'(mEnter));
    chk("R10 exitStb", int'(exitStb), int'(mLeave));
    chk("R11 idleCycles", int'(idleCycles), mIdle);
    clearPulses();
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 state", int'(pwrState), 0);
    chk("R1 cmdBlock", int'(cmdBlock), 0);
    chk("R1 idle", int'(idleCycles), 0);
    chk("R1 strobes", int'(enterStb) + int'(exitStb), 0);

    // open nap with wake request in the first sleep cycle
    banksOpen = 1; step();
    chk("R2 to banks-open", int'(pwrState), 1);
    rdEnq = 1; step();
    rdRespSched = 1; step();
    rdDone = 1; step();
    chk("R4 open nap", int'(pwrState), 2);
    chk("R10 entry strobe", int'(enterStb), 1);
    chk("R9 block asleep", int'(cmdBlock), 1);
    wakeReq = 1; step();
    chk("R6 held asleep", int'(pwrState), 2);
    step();
    chk("R7 open nap wakes to banks-open", int'(pwrState), 1);
    chk("R10 exit strobe", int'(exitStb), 1);
    chk("R11 two sleep cycles", int'(idleCycles), 2);
    for (int j = 1; j < TXP; j++) begin
      step();
      chk("R9 tXP window", int'(cmdBlock), 1);
    end
    step();
    chk("R9 tXP window end", int'(cmdBlock), 0);

    // last precharge while ready -> closed nap, then self-refresh
    preSched = 1; step();
    preDone = 1; step();
    chk("R5 closed nap", int'(pwrState), 3);
    banksOpen = 0;
    srefReq = 1; step();
    chk("R6 sref held off", int'(pwrState), 3);
    srefReq = 1; step();
    chk("R8 self-refresh", int'(pwrState), 4);
    chk("R10 sref entry strobe", int'(enterStb), 1);
    wakeReq = 1; step();
    chk("R8 wake ignored", int'(pwrState), 4);
    wakeReq = 1; step();
    chk("R8 wake ignored again", int'(pwrState), 4);
    rdEnq = 1; step();
    chk("R8 still asleep", int'(pwrState), 4);
    step();
    chk("R8 queued read wakes", int'(pwrState), 0);
    chk("R10 sref exit strobe", int'(exitStb), 1);
    for (int j = 1; j < TXS; j++) begin
      step();
      chk("R9 tXS window", int'(cmdBlock), 1);
    end
    step();
    chk("R9 tXS window end", int'(cmdBlock), 0);
    rdRespSched = 1; step();
    rdDone = 1; step();
    chk("R4 idle to closed nap", int'(pwrState), 3);
    step(); step();
    wakeReq = 1; srefReq = 1; step();
    chk("R7 wake beats sref", int'(pwrState), 0);
    repeat (TXP) step();

    // not-ready cases
    banksOpen = 1; step();
    wrEnq = 1; nextDirWrite = 1; step();
    preSched = 1; step();
    preDone = 1; step();
    chk("R5 not ready goes idle", int'(pwrState), 0);
    step();
    chk("R2 reopen", int'(pwrState), 1);
    rdEnq = 1; step();
    rdRespSched = 1; step();
    rdDone = 1; step();
    chk("R3 write pending keeps awake", int'(pwrState), 1);
    wrIssue = 1; step();
    wrDone = 1; step();
    chk("R3 no trigger no sleep", int'(pwrState), 1);
    preSched = 1; step();
    preDone = 1; step();
    chk("R5 closed nap after writes", int'(pwrState), 3);
    banksOpen = 0; nextDirWrite = 0; step();
    wakeReq = 1; step();
    chk("R7 closed nap wakes idle", int'(pwrState), 0);
    repeat (TXP) step();
    srefReq = 1; step();
    chk("R8 sref ignored in idle", int'(pwrState), 0);
    refActive = 1; banksOpen = 1; step();
    chk("R2 refresh", int'(pwrState), 5);
    step();
    chk("R2 refresh holds", int'(pwrState), 5);
    refActive = 0; banksOpen = 0; step();
    chk("R2 refresh done", int'(pwrState), 0);

    // saturation of the sleep counter
    rdEnq = 1; step();
    rdRespSched = 1; step();
    rdDone = 1; step();
    repeat (IDLE_MAX + 8) step();
    chk("R11 saturates", int'(idleCycles), IDLE_MAX);
    wakeReq = 1; step();
    chk("R7 wake after long nap", int'(pwrState), 0);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      rdEnq = (mRd < 40) && ($urandom % 8 == 0);
      wrEnq = (mWr < 40) && ($urandom % 8 == 0);
      rdRespSched = (mEv < 40) && ($urandom % 8 == 0);
      wrIssue = (mWr > 0) && (mEv < 40) && ($urandom % 6 == 0);
      preSched = (mEv < 40) && ($urandom % 10 == 0);
      r = int'($urandom % 6);
      if (r == 0 && mRd > 0 && mEv > 0) rdDone = 1;
      else if (r == 1 && mEv > 0) wrDone = 1;
      else if (r == 2 && mEv > 0) preDone = 1;
      if ($urandom % 12 == 0) banksOpen = 4'($urandom % 3);
      if ($urandom % 20 == 0) nextDirWrite = ~nextDirWrite;
      if ($urandom % 40 == 0) refActive = ~refActive;
      wakeReq = ($urandom % 7 == 0);
      srefReq = ($urandom % 4 == 0);
      step();
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule